// File: doc/BRIEF.md
# Dual-Clock Power Mode Controller

This block decides which clocks of a small controller run at any moment. It keeps one of four operating modes and turns it into gate enables for the fast clock domain, the slow clock domain, the CPU clock and the time-base timer. Software changes the mode by writing a 2-bit request. Two keep bits choose whether the clock that is not driving the CPU stays enabled. A set of wake-up event lines brings the device back from the two low-power modes.

Mode codes are 00 = FAST, 01 = SLOW, 10 = IDLE and 11 = STOP. When the device enters IDLE or STOP it remembers the mode it was in, and a wake-up event returns it to that mode. The fast oscillator is off in both low-power modes. When a wake-up returns the device to FAST, the CPU clock stays gated for a fixed number of slow-clock cycles so the oscillator can settle. The slow clock is given as a one-cycle tick input.

The oscillators, the CPU and the timers are not part of this block. The clock gates are plain enable signals.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the mode is FAST (00). `fast_en`, `cpu_en` and `tb_en` are 1, `cpu_halted` is 0, and `slow_en` follows `slow_keep`.
- R2: `mode` always shows the current mode as 00 FAST, 01 SLOW, 10 IDLE or 11 STOP. During fast-clock settling it shows 00.
- R3: In FAST, outside settling, `fast_en`, `cpu_en` and `tb_en` are 1, and `slow_en` equals `slow_keep` in the same cycle.
- R4: In SLOW, `slow_en`, `cpu_en` and `tb_en` are 1, and `fast_en` equals `fast_keep` in the same cycle.
- R5: In IDLE, `fast_en` and `cpu_en` are 0, `slow_en` and `tb_en` are 1, and `cpu_halted` is 1.
- R6: In STOP, `fast_en`, `slow_en`, `cpu_en` and `tb_en` are all 0, and `cpu_halted` is 1.
- R7: A write pulse (`mode_wr`=1) takes effect on `mode` in the cycle after it is sampled. A request for SLOW from FAST needs `slow_keep`=1, and a request for FAST from SLOW needs `fast_keep`=1. Otherwise the request is ignored and the mode is kept. A request for the current mode changes nothing.
- R8: Writes made in IDLE, in STOP or during settling are ignored. Wake-up events sampled in FAST or SLOW have no effect.
- R9: In IDLE or STOP, any bit of `wake_evt` sampled high returns `mode` to the mode held before entry, in the next cycle.
- R10: After a wake-up into FAST, `cpu_en` stays 0 and `fast_en` and `slow_en` stay 1. `cpu_en` becomes 1 in the cycle after the 16th `slow_tick` pulse sampled after the wake-up cycle. A tick in the wake-up cycle itself is not counted.
- R11: After a wake-up into SLOW, `cpu_en` is 1 immediately, with no settling hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Mode request write strobe |
| mode_wdata | input | 2 | Requested mode code |
| slow_keep | input | 1 | Keep slow clock enabled while in FAST |
| fast_keep | input | 1 | Keep fast clock enabled while in SLOW |
| wake_evt | input | NUM_WAKE | Wake-up event lines (pins and timers) |
| slow_tick | input | 1 | One-cycle pulse per slow-clock cycle |
| fast_en | output | 1 | Fast clock domain enable |
| slow_en | output | 1 | Slow clock domain enable |
| cpu_en | output | 1 | CPU clock enable |
| tb_en | output | 1 | Time-base and wake-up timer enable |
| cpu_halted | output | 1 | CPU clock is stopped |
| mode | output | 2 | Current mode code |

## Verification
Because every output is decoded from the registered mode, a wrong mode or a lost remembered mode shows on `mode` and on the clock gates in the cycle after the edge that caused it. A settling counter that is off by even one tick moves the rising edge of `cpu_en` by one or more cycles. The reference model predicts that edge cycle by cycle. A rejected request that still switches the mode, or a write that is wrongly taken in a low-power mode, changes `mode` in the very next cycle.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {
    MODE_FAST = 2'b00,
    MODE_SLOW = 2'b01,
    MODE_IDLE = 2'b10,
    MODE_STOP = 2'b11
  } pmc_mode_e;
endpackage

// File: rtl/pmc_rst_sync.sv
module pmc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ni
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_ni = sync_q[STAGES-1];
endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
  import pmc_pkg::*;
#(
  parameter int NUM_WAKE = 4
) (
  input  logic                clk,
  input  logic                rst_ni,
  input  logic                mode_wr,
  input  logic [1:0]          mode_wdata,
  input  logic                slow_keep,
  input  logic                fast_keep,
  input  logic [NUM_WAKE-1:0] wake_evt,
  input  logic                settling,
  output pmc_mode_e           mode_q,
  output logic                settle_start
);
  pmc_mode_e mode_d, prev_q, prev_d, req;
  logic      low_power, any_wake;

  assign req       = pmc_mode_e'(mode_wdata);
  assign low_power = (mode_q == MODE_IDLE) || (mode_q == MODE_STOP);
  assign any_wake  = |wake_evt;

  always_comb begin
    mode_d       = mode_q;
    prev_d       = prev_q;
    settle_start = 1'b0;
    if (low_power) begin
      if (any_wake) begin
        mode_d       = prev_q;
        settle_start = (prev_q == MODE_FAST);
      end
    end else if (mode_wr && !settling) begin
      unique case (req)
        MODE_FAST: if (mode_q == MODE_SLOW && fast_keep) mode_d = MODE_FAST;
        MODE_SLOW: if (mode_q == MODE_FAST && slow_keep) mode_d = MODE_SLOW;
        default: begin
          prev_d = mode_q;
          mode_d = req;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_FAST;
      prev_q <= MODE_FAST;
    end else begin
      mode_q <= mode_d;
      prev_q <= prev_d;
    end
  end

  AST_WAKE_RESTORE: assert property (@(posedge clk) disable iff (!rst_ni)
    (low_power && any_wake) |=> (mode_q == $past(prev_q))) else $error("wake restore"); // R9

  AST_REJECT_SLOW: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode_q == MODE_FAST && mode_wr && mode_wdata == 2'b01 && !slow_keep)
    |=> (mode_q == MODE_FAST)) else $error("slow reject"); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode_q == MODE_IDLE && !any_wake) |=> (mode_q == MODE_IDLE)) else $error("idle hold"); // R8
endmodule

// File: rtl/pmc_settle.sv
module pmc_settle #(
  parameter int SETTLE_TICKS = 16
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic start,
  input  logic slow_tick,
  output logic settling
);
  localparam int CNT_W = (SETTLE_TICKS > 1) ? $clog2(SETTLE_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_TICKS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (start) begin
      cnt_d  = '0;
      busy_d = 1'b1;
    end else if (busy_q && slow_tick) begin
      if (cnt_q == LAST) begin
        busy_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign settling = busy_q;

  AST_SETTLE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy_q && !slow_tick) |=> busy_q) else $error("settle ended without tick"); // R10
endmodule

// File: rtl/pmc_gates.sv
module pmc_gates
  import pmc_pkg::*;
(
  input  pmc_mode_e mode,
  input  logic      settling,
  input  logic      slow_keep,
  input  logic      fast_keep,
  output logic      fast_en,
  output logic      slow_en,
  output logic      cpu_en,
  output logic      tb_en
);
  always_comb begin
    fast_en = 1'b0;
    slow_en = 1'b0;
    cpu_en  = 1'b0;
    tb_en   = 1'b0;
    unique case (mode)
      MODE_FAST: begin
        fast_en = 1'b1;
        slow_en = slow_keep | settling;
        cpu_en  = ~settling;
        tb_en   = 1'b1;
      end
      MODE_SLOW: begin
        fast_en = fast_keep;
        slow_en = 1'b1;
        cpu_en  = 1'b1;
        tb_en   = 1'b1;
      end
      MODE_IDLE: begin
        slow_en = 1'b1;
        tb_en   = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int NUM_WAKE     = 4,
  parameter int SETTLE_TICKS = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode_wr,
  input  logic [1:0]          mode_wdata,
  input  logic                slow_keep,
  input  logic                fast_keep,
  input  logic [NUM_WAKE-1:0] wake_evt,
  input  logic                slow_tick,
  output logic                fast_en,
  output logic                slow_en,
  output logic                cpu_en,
  output logic                tb_en,
  output logic                cpu_halted,
  output logic [1:0]          mode
);
  logic      rst_ni, settling, settle_start;
  pmc_mode_e mode_q;

  pmc_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .rst_n(rst_n), .rst_ni(rst_ni));

  pmc_mode_fsm #(.NUM_WAKE(NUM_WAKE)) u_fsm (
    .clk(clk), .rst_ni(rst_ni), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .slow_keep(slow_keep), .fast_keep(fast_keep), .wake_evt(wake_evt),
    .settling(settling), .mode_q(mode_q), .settle_start(settle_start)
  );

  pmc_settle #(.SETTLE_TICKS(SETTLE_TICKS)) u_settle (
    .clk(clk), .rst_ni(rst_ni), .start(settle_start),
    .slow_tick(slow_tick), .settling(settling)
  );

  pmc_gates u_gates (
    .mode(mode_q), .settling(settling), .slow_keep(slow_keep), .fast_keep(fast_keep),
    .fast_en(fast_en), .slow_en(slow_en), .cpu_en(cpu_en), .tb_en(tb_en)
  );

  assign cpu_halted = ~cpu_en;
  assign mode       = mode_q;

  AST_HOLD_CPU: assert property (@(posedge clk) disable iff (!rst_ni)
    settling |-> (!cpu_en && fast_en)) else $error("cpu ran while settling"); // R10

  AST_STOP_GATES: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode == 2'b11) |-> !(fast_en || slow_en || cpu_en || tb_en)) else $error("stop gates"); // R6

  AST_IDLE_GATES: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode == 2'b10) |-> (slow_en && tb_en && !fast_en && cpu_halted)) else $error("idle gates"); // R5
endmodule

// File: tb/tb_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module tb_pwr_mode_ctrl;
  localparam int NW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_wr = 1'b0;
  logic [1:0] mode_wdata = 2'b00;
  logic slow_keep = 1'b0, fast_keep = 1'b0;
  logic [NW-1:0] wake_evt = '0;
  logic slow_tick = 1'b0;
  logic fast_en, slow_en, cpu_en, tb_en, cpu_halted;
  logic [1:0] mode;

  int checks = 0, errors = 0;
  bit done = 0;
  string tag = "R1";

  int m_mode = 0, m_prev = 0, m_left = 0;
  int tick_cnt = 0;

  always #2.5 clk = ~clk;

  pwr_mode_ctrl #(.NUM_WAKE(NW), .SETTLE_TICKS(16)) dut (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .slow_keep(slow_keep), .fast_keep(fast_keep), .wake_evt(wake_evt),
    .slow_tick(slow_tick), .fast_en(fast_en), .slow_en(slow_en), .cpu_en(cpu_en),
    .tb_en(tb_en), .cpu_halted(cpu_halted), .mode(mode)
  );

  // reference model, advanced at each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_prev = 0; m_left = 0;
    end else if (m_left > 0) begin
      if (slow_tick) m_left = m_left - 1;
    end else if (m_mode >= 2) begin
      if (|wake_evt) begin
        m_mode = m_prev;
        if (m_prev == 0) m_left = 16;
      end
    end else if (mode_wr) begin
      if (mode_wdata == 2'd0) begin
        if (m_mode == 1 && fast_keep) m_mode = 0;
      end else if (mode_wdata == 2'd1) begin
        if (m_mode == 0 && slow_keep) m_mode = 1;
      end else begin
        m_prev = m_mode;
        m_mode = int'(mode_wdata);
      end
    end
  end

  // slow tick: one pulse every third cycle
  always @(negedge clk) begin
    #1;
    tick_cnt = (tick_cnt + 1) % 3;
    slow_tick = (tick_cnt == 0);
  end

  task automatic chk(string name, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, name, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      logic ef, es, ec, et;
      if (m_left > 0) begin ef = 1; es = 1; ec = 0; et = 1; end
      else case (m_mode)
        0: begin ef = 1; es = slow_keep; ec = 1; et = 1; end
        1: begin ef = fast_keep; es = 1; ec = 1; et = 1; end
        2: begin ef = 0; es = 1; ec = 0; et = 1; end
        default: begin ef = 0; es = 0; ec = 0; et = 0; end
      endcase
      chk("fast_en", fast_en, ef);
      chk("slow_en", slow_en, es);
      chk("cpu_en", cpu_en, ec);
      chk("tb_en", tb_en, et);
      chk("cpu_halted", cpu_halted, ~ec);
      checks++;
      if (mode !== 2'(m_mode)) begin
        errors++;
        $display("FAIL %s R2 mode actual=%0d expected=%0d t=%0t", tag, mode, m_mode, $time);
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(logic [1:0] m);
    mode_wr = 1'b1; mode_wdata = m;
    cyc(1);
    mode_wr = 1'b0;
    cyc(2);
  endtask

  task automatic wake(int bitno);
    wake_evt = '0; wake_evt[bitno] = 1'b1;
    cyc(1);
    wake_evt = '0;
  endtask

  initial begin
    #200_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    tag = "R1"; cyc(5);
    tag = "R3"; slow_keep = 1; cyc(3); slow_keep = 0; cyc(3);
    tag = "R7"; wr(2'd1);             // rejected: slow not kept
    wr(2'd0);                         // same mode, no change
    slow_keep = 1; wr(2'd1);          // accepted -> SLOW
    tag = "R4"; fast_keep = 1; cyc(3); fast_keep = 0; cyc(3);
    tag = "R7"; wr(2'd0);             // rejected: fast not kept
    wr(2'd1);
    tag = "R8"; wake(1); cyc(2);      // wake in SLOW ignored
    tag = "R5"; wr(2'd2); cyc(4);
    tag = "R8"; wr(2'd0); wr(2'd3); cyc(2);
    tag = "R11"; wake(0); cyc(3);
    tag = "R9"; fast_keep = 1; wr(2'd0); cyc(2);
    slow_keep = 1; wr(2'd2); cyc(3);
    tag = "R10"; slow_keep = 0; wake(2);
    cyc(5); wr(2'd1); wr(2'd3);       // writes during settling ignored
    cyc(60);
    tag = "R6"; wr(2'd3); cyc(5);
    tag = "R8"; wr(2'd1); cyc(2);
    tag = "R10"; wake(3); cyc(60);
    tag = "R9"; slow_keep = 1; wr(2'd1); cyc(2);
    tag = "R6"; fast_keep = 0; wr(2'd3); cyc(4);
    tag = "R11"; wake(1); cyc(4);
    tag = "R1"; rst_n = 1'b0; cyc(3); rst_n = 1'b1; cyc(4);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule